// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Queue and Line-Break Detection

This block turns an asynchronous serial line into characters. It runs from a system clock and uses a one-cycle enable pulse, `tick16`, that fires sixteen times per bit period. On each of these ticks it hunts for a start bit and confirms it. It then samples every later bit at the centre of the bit. Each finished character is stored with its own parity-error and framing-error flags in a four-entry queue. The consumer reads the queue from its head.

The character format is set by static inputs: the number of data bits, the parity rule and the level of a fixed parity bit. These must match the settings of the far-end transmitter. A channel-mode input chooses the receive source. The source is either the external line or the local transmitter's serial output, which gives a self-test loop. The block also keeps three sticky flags: queue overrun, break-begun and break-ended. One clear input resets all three.

A break is a whole frame held low. It is reported and is never stored as a character. If the line drops low partway through a character, that character is stored with a framing error, and the break is then reported on the frame that follows.

Top module: `serial_rx_unit`

## Requirements
- R1: A low level seen on a tick starts a start-bit check. If the line is high again at the 8th tick after detection, the receiver goes back to hunting and stores nothing.
- R2: The data length is `len_code`+5 bits (00=5 up to 11=8). Bits arrive LSB first. Unused upper bits of `rd_data` read as zero.
- R3: `par_mode` 00 means no parity bit, 01 even, 10 odd, and 11 a fixed parity bit equal to `par_fixed`. A received parity bit that differs from the expected value sets `rd_perr` for that character only.
- R4: When the first stop bit is sampled low, the character is stored with `rd_ferr`=1. A second stop bit is treated as idle line.
- R5: The queue holds four characters and returns them in arrival order. `rx_ready` is 1 while at least one character is stored. `fifo_full` is 1 while all four entries are in use. A `pop` pulse removes the head.
- R6: A character that completes while the queue is full is discarded and sets `overrun`. `overrun` stays set until `clr_flags` is pulsed.
- R7: A frame whose data bits, parity bit and stop bit are all low sets `brk_begin` and stores no character. `brk_done` is set when the line next returns high. Both flags stay set until `clr_flags` is pulsed.
- R8: If the line falls low in the middle of a character and stays low, the partial character is stored with a framing error and the break is then reported as in R7.
- R9: With `loop_sel`=1 the receiver reads `tx_loop_in` and ignores `line_in`. With `loop_sel`=0 it reads `line_in`.
- R10: After reset the queue is empty and `rx_ready`, `fifo_full`, `overrun`, `brk_begin` and `brk_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversample enable, 16 pulses per bit |
| loop_sel | input | 1 | 1 selects the local transmitter output as the source |
| line_in | input | 1 | External serial line |
| tx_loop_in | input | 1 | Local transmitter serial output |
| len_code | input | 2 | Data length minus five |
| par_mode | input | 2 | Parity rule: none, even, odd, fixed |
| par_fixed | input | 1 | Level of the fixed parity bit |
| pop | input | 1 | Remove the head character |
| clr_flags | input | 1 | Clear overrun and break flags |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character framing error |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | All entries in use |
| overrun | output | 1 | Sticky overrun flag |
| brk_begin | output | 1 | Sticky break-start flag |
| brk_done | output | 1 | Sticky break-end flag |

## Verification
Characters are sent with every data length and every parity rule. The data values include all-zero and all-one patterns, which separate bit-order and masking faults from parity faults. Wrong parity bits, a stop bit held low, and a start glitch show whether each error flag is tied to its own character and whether the start-bit check rejects noise. A fully held-low frame and a line that drops partway through a character distinguish a true break from a framing error. Filling the queue past four entries with reads paused exercises the full flag and overrun. A frame sent on the loopback source while the external line is held low confirms the source select.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FIFO_DEPTH = 4;
    localparam int unsigned OSR        = 16;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_FIXED = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_entry_t;

    // Parity bit a correct transmitter would send for these data bits.
    function automatic logic exp_parity(logic [DATA_W-1:0] d, par_mode_e m, logic fixed_lvl);
        case (m)
            PAR_EVEN:  return ^d;
            PAR_ODD:   return ~^d;
            PAR_FIXED: return fixed_lvl;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_sel,
    input  logic line_in,
    input  logic tx_loop_in,
    output logic rx_s
);
    logic raw;
    logic [SYNC_STAGES-1:0] sync_q;

    assign raw = loop_sel ? tx_loop_in : line_in;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    assign rx_s = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rxu_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = OSR
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx_s,
    input  logic [1:0] len_code,
    input  par_mode_e pmode,
    input  logic      pfix,
    output logic      done,
    output logic      is_break,
    output rx_entry_t frame,
    output logic      brk_end
);
    localparam int unsigned CW    = $clog2(OVERSAMPLE);
    localparam int unsigned IW    = $clog2(DATA_W);
    localparam logic [CW-1:0] HALF = CW'(OVERSAMPLE/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     bit_idx;
    logic [IW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_s;
    logic              brk_now;

    assign last_idx = IW'(len_code) + IW'(4);
    assign brk_now  = !rx_s && (shreg == '0) && (pmode == PAR_NONE || !par_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_s    <= 1'b0;
            done     <= 1'b0;
            is_break <= 1'b0;
            frame    <= '0;
            brk_end  <= 1'b0;
        end else begin
            done    <= 1'b0;
            brk_end <= 1'b0;
            if (tick) begin
                case (state)
                    ST_HUNT: begin
                        if (!rx_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            if (!rx_s) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_s   <= 1'b0;
                            end else begin
                                state <= ST_HUNT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rx_s;
                            if (bit_idx == last_idx)
                                state <= (pmode == PAR_NONE) ? ST_STOP : ST_PAR;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            par_s <= rx_s;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            done       <= 1'b1;
                            is_break   <= brk_now;
                            frame.data <= shreg;
                            frame.perr <= (pmode != PAR_NONE) &&
                                          (par_s != exp_parity(shreg, pmode, pfix));
                            frame.ferr <= !rx_s;
                            state      <= brk_now ? ST_BRK : ST_HUNT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRK: begin
                        if (rx_s) begin
                            brk_end <= 1'b1;
                            state   <= ST_HUNT;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxu_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] fill,
    output logic             drop
);
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;
    rx_entry_t        slots [DEPTH];

    assign do_push = push && (fill != CNT_W'(DEPTH));
    assign do_pop  = pop && (fill != '0);
    assign drop    = push && (fill == CNT_W'(DEPTH));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            rx_entry_t slot_q;
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q <= '0;
                else if (do_push && wr_ptr == PTR_W'(g))
                    slot_q <= push_entry;
            end
            assign slots[g] = slot_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import rxu_pkg::*;
#(
    parameter int unsigned DEPTH       = FIFO_DEPTH,
    parameter int unsigned OVERSAMPLE  = OSR,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              loop_sel,
    input  logic              line_in,
    input  logic              tx_loop_in,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              par_fixed,
    input  logic              pop,
    input  logic              clr_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              overrun,
    output logic              brk_begin,
    output logic              brk_done
);
    logic             rx_s;
    logic             f_done, f_brk, f_brk_end, q_drop;
    rx_entry_t        f_entry, q_head;
    logic [CNT_W-1:0] fill;

    rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .loop_sel   (loop_sel),
        .line_in    (line_in),
        .tx_loop_in (tx_loop_in),
        .rx_s       (rx_s)
    );

    rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rx_s     (rx_s),
        .len_code (len_code),
        .pmode    (par_mode_e'(par_mode)),
        .pfix     (par_fixed),
        .done     (f_done),
        .is_break (f_brk),
        .frame    (f_entry),
        .brk_end  (f_brk_end)
    );

    rx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (f_done && !f_brk),
        .push_entry (f_entry),
        .pop        (pop),
        .head       (q_head),
        .fill       (fill),
        .drop       (q_drop)
    );

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            overrun   <= 1'b0;
            brk_begin <= 1'b0;
            brk_done  <= 1'b0;
        end else begin
            overrun   <= q_drop              | (overrun   & ~clr_flags);
            brk_begin <= (f_done & f_brk)    | (brk_begin & ~clr_flags);
            brk_done  <= f_brk_end           | (brk_done  & ~clr_flags);
        end
    end

    assign rd_data   = q_head.data;
    assign rd_perr   = q_head.perr;
    assign rd_ferr   = q_head.ferr;
    assign rx_ready  = (fill != '0);
    assign fifo_full = (fill == CNT_W'(DEPTH));
endmodule

// File: rtl/rx_unit_checks.sv
module rx_unit_checks #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_flags,
    input logic             rx_ready,
    input logic             fifo_full,
    input logic             overrun,
    input logic             brk_begin,
    input logic [CNT_W-1:0] fill
);
    // R5: a full queue is also a non-empty one
    a_r5_full_has_ready: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rx_ready);

    // R5: occupancy never passes the depth
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R5: occupancy moves by at most one per cycle
    a_r5_fill_step: assert property (@(posedge clk) disable iff (rst)
        (fill != $past(fill)) |-> (fill == $past(fill) + 1'b1 || fill + 1'b1 == $past(fill)));

    // R6: overrun holds until cleared
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_flags) |=> overrun);

    // R6: overrun only rises out of a full queue
    a_r6_overrun_from_full: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(fifo_full));

    // R7: break-start flag holds until cleared
    a_r7_brk_sticky: assert property (@(posedge clk) disable iff (rst)
        (brk_begin && !clr_flags) |=> brk_begin);
endmodule

bind serial_rx_unit rx_unit_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_flags (clr_flags),
    .rx_ready  (rx_ready),
    .fifo_full (fifo_full),
    .overrun   (overrun),
    .brk_begin (brk_begin),
    .fill      (fill)
);

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       loop_sel = 1'b0;
    logic       line_in = 1'b1;
    logic       tx_loop_in = 1'b1;
    logic [1:0] len_code = 2'b11;
    logic [1:0] par_mode = 2'b00;
    logic       par_fixed = 1'b0;
    logic       pop = 1'b0;
    logic       clr_flags = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rx_ready, fifo_full, overrun, brk_begin, brk_done;

    int checks = 0;
    int errors = 0;
    bit auto_pop = 1'b1;
    logic [9:0] exp_q [$];

    always #4 clk = ~clk;

    serial_rx_unit u_serial_rx_unit (
        .clk(clk), .rst(rst), .tick16(tick16), .loop_sel(loop_sel),
        .line_in(line_in), .tx_loop_in(tx_loop_in), .len_code(len_code),
        .par_mode(par_mode), .par_fixed(par_fixed), .pop(pop), .clr_flags(clr_flags),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .overrun(overrun), .brk_begin(brk_begin), .brk_done(brk_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One tick every four clocks; a bit lasts 64 clocks.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic drive(input logic lvl, input int ticks, input bit via_loop);
        if (via_loop) tx_loop_in = lvl;
        else          line_in    = lvl;
        repeat (ticks * 4) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int len, input logic [1:0] pm,
                             input logic pf, input bit bad_par, input bit bad_stop,
                             input bit via_loop, input bit expect_push);
        logic [7:0] m;
        logic       p;
        m = d & 8'((1 << len) - 1);
        case (pm)
            2'b01:   p = ^m;
            2'b10:   p = ~^m;
            2'b11:   p = pf;
            default: p = 1'b0;
        endcase
        len_code  = 2'(len - 5);
        par_mode  = pm;
        par_fixed = pf;
        if (expect_push) exp_q.push_back({m, bad_par && (pm != 2'b00), bad_stop});
        drive(1'b0, 16, via_loop);
        for (int i = 0; i < len; i++) drive(m[i], 16, via_loop);
        if (pm != 2'b00) drive(p ^ bad_par, 16, via_loop);
        if (bad_stop) begin
            drive(1'b0, 11, via_loop);
            drive(1'b1, 21, via_loop);
        end else begin
            drive(1'b1, 32, via_loop);
        end
    endtask

    task automatic pulse_clear();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor: pops each ready head and compares it with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_pop && !rst && rx_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R5: unexpected character actual %0h expected none", rd_data);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check("R2 data", {24'b0, rd_data}, {24'b0, e[9:2]});
                    check("R3 parity flag", {31'b0, rd_perr}, {31'b0, e[1]});
                    check("R4 framing flag", {31'b0, rd_ferr}, {31'b0, e[0]});
                end
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 ready", {31'b0, rx_ready}, 0);
        check("R10 full", {31'b0, fifo_full}, 0);
        check("R10 flags", {29'b0, overrun, brk_begin, brk_done}, 0);
        drive(1'b1, 32, 1'b0);

        // R2/R3 lengths and parity rules
        send_char(8'hA5, 8, 2'b00, 1'b0, 0, 0, 0, 1);
        send_char(8'h13, 5, 2'b01, 1'b0, 0, 0, 0, 1);
        send_char(8'hDA, 7, 2'b10, 1'b0, 0, 0, 0, 1);
        send_char(8'h2C, 6, 2'b11, 1'b1, 0, 0, 0, 1);
        send_char(8'hFF, 8, 2'b01, 1'b0, 0, 0, 0, 1);
        send_char(8'h00, 8, 2'b10, 1'b0, 0, 0, 0, 1);
        // R3 wrong parity, including fixed level
        send_char(8'h3C, 8, 2'b01, 1'b0, 1, 0, 0, 1);
        send_char(8'h7F, 8, 2'b11, 1'b0, 1, 0, 0, 1);
        // R4 framing error on a low stop bit
        send_char(8'h81, 8, 2'b00, 1'b0, 0, 1, 0, 1);

        // R1 start glitch shorter than half a bit
        drive(1'b0, 4, 1'b0);
        drive(1'b1, 40, 1'b0);
        check("R1 glitch stores nothing", {31'b0, rx_ready}, 0);
        check("R1 scoreboard drained", exp_q.size(), 0);

        // R9 loopback source while the external line sits low
        loop_sel = 1'b1;
        repeat (8) @(negedge clk);
        line_in = 1'b0;
        send_char(8'h5E, 8, 2'b01, 1'b0, 0, 0, 1, 1);
        check("R9 line ignored, no break", {31'b0, brk_begin}, 0);
        line_in = 1'b1;
        repeat (8) @(negedge clk);
        loop_sel = 1'b0;
        drive(1'b1, 16, 1'b0);
        check("R9 loop char consumed", exp_q.size(), 0);

        // R5/R6 fill queue with reads paused
        auto_pop = 1'b0;
        send_char(8'h11, 8, 2'b00, 1'b0, 0, 0, 0, 1);
        check("R5 ready after one", {31'b0, rx_ready}, 1);
        check("R5 not full after one", {31'b0, fifo_full}, 0);
        send_char(8'h22, 8, 2'b00, 1'b0, 0, 0, 0, 1);
        send_char(8'h33, 8, 2'b00, 1'b0, 0, 0, 0, 1);
        send_char(8'h44, 8, 2'b00, 1'b0, 0, 0, 0, 1);
        check("R5 full at four", {31'b0, fifo_full}, 1);
        check("R6 no overrun yet", {31'b0, overrun}, 0);
        send_char(8'h55, 8, 2'b00, 1'b0, 0, 0, 0, 0);
        check("R6 overrun set", {31'b0, overrun}, 1);
        check("R5 still full", {31'b0, fifo_full}, 1);
        auto_pop = 1'b1;
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        check("R5 empty after drain", {31'b0, rx_ready}, 0);
        check("R6 overrun sticky", {31'b0, overrun}, 1);
        pulse_clear();
        check("R6 overrun cleared", {31'b0, overrun}, 0);

        // R7 full break frame
        len_code = 2'b11;
        par_mode = 2'b00;
        drive(1'b0, 16 * 14, 1'b0);
        check("R7 break start", {31'b0, brk_begin}, 1);
        check("R7 no end while low", {31'b0, brk_done}, 0);
        check("R7 no character", {31'b0, rx_ready}, 0);
        drive(1'b1, 32, 1'b0);
        check("R7 break end", {31'b0, brk_done}, 1);
        check("R7 no character after", exp_q.size(), 0);
        pulse_clear();
        check("R7 flags cleared", {30'b0, brk_begin, brk_done}, 0);

        // R8 line drops inside a character (8N1, bits 1,1 then low)
        exp_q.push_back({8'h03, 1'b0, 1'b1});
        drive(1'b0, 16, 1'b0);
        drive(1'b1, 32, 1'b0);
        drive(1'b0, 16 * 25, 1'b0);
        check("R8 break after partial", {31'b0, brk_begin}, 1);
        drive(1'b1, 32, 1'b0);
        check("R8 break end", {31'b0, brk_done}, 1);
        repeat (4) @(negedge clk);
        check("R8 partial char consumed", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule